// File: doc/BRIEF.md
# Pulse-Width Classifying Rate Counter

This block is one channel of a per-input rate meter. It watches a single asynchronous input line, sorts each pulse on that line by its length in sampling-clock periods, and counts the pulses that match a host-selected mode. Another mode adds up the clock periods during which the input is high. A one-second gate strobe, generated outside the block, closes each counting window. On the strobe the running total is copied into a published field and counting restarts from zero.

The host reaches the channel through one 32-bit register word. The upper nibble holds the mode and can be written and read back. The lower field holds the last published total and is read-only. Pulses shorter than one clock period never appear in the clocked samples. An edge flag, toggled by the input itself and brought into the clock domain, makes sure they are still seen.

Top module: `pwc_rate_counter`

## Requirements
- R1: After reset the register word reads 0x00000000: the mode is off and the published count is zero.
- R2: A write stores bits 31:28 as the mode, and the mode reads back on bits 31:28. Bits 27:26 always read zero. The count field (bits 25:0) ignores written data and shows only the published count, zero-extended from CNT_W bits.
- R3: Mode code 0 and every code other than 5, 6, 7, 10, 11, 14 and 15 count nothing.
- R4: Mode 5 counts each pulse that raised the input but was never high at a sampling clock edge.
- R5: Mode 6 counts each pulse seen high at one or more clock edges, once per pulse. Mode 7 counts pulses seen high at exactly one clock edge.
- R6: Mode 10 counts pulses seen high at two or more edges, once per pulse. Mode 11 counts pulses seen high at exactly two edges.
- R7: Mode 14 counts pulses seen high at three or more edges, once per pulse.
- R8: Mode 15 adds one for every clock edge at which the input is sampled high.
- R9: A gate strobe copies the running count into the count field and restarts the running count from zero. Between strobes the count field does not change.
- R10: The running count saturates at 2^CNT_W-1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data (mode in bits 31:28) |
| regRdData | output | 32 | Register read data: mode, zero gap, published count |
| pulseIn | input | 1 | Asynchronous input pulse line |
| gateTick | input | 1 | One-cycle gate strobe that closes a counting window |

## Verification
Every mode is run against the same mixed train: two sub-period pulses, three one-period pulses, two two-period pulses, one three-period pulse and one five-period pulse. Because the train is the same, each mode's total (2, 7, 3, 4, 2, 2, 15) tells that mode apart from its neighbours. The pair 6 and 7 separates "at least" counting from "exactly" counting, and so does the pair 10 and 11. The five-period pulse shows that the "at least" modes count a long pulse only once. The off and unused codes are run on the same train and must publish zero. A long high level in mode 15 drives the count into saturation. Back-to-back strobes show that counting restarts and that the published value holds between strobes.

// File: rtl/pwc_pkg.sv
`timescale 1ns/1ps
package pwc_pkg;
  localparam logic [3:0] MODE_OFF   = 4'h0;
  localparam logic [3:0] MODE_SHORT = 4'h5;
  localparam logic [3:0] MODE_GE1   = 4'h6;
  localparam logic [3:0] MODE_EQ1   = 4'h7;
  localparam logic [3:0] MODE_GE2   = 4'hA;
  localparam logic [3:0] MODE_EQ2   = 4'hB;
  localparam logic [3:0] MODE_GE3   = 4'hE;
  localparam logic [3:0] MODE_HIGH  = 4'hF;

  // qualified pulse events from the input front end, one clock wide
  typedef struct packed {
    logic shortPulse;
    logic levelHigh;
    logic reach1;
    logic reach2;
    logic reach3;
    logic fallEq1;
    logic fallEq2;
  } pulseEvt_t;

  // strobes from control to the count datapath
  typedef struct packed {
    logic bump;
    logic publish;
  } accStrobe_t;
endpackage

// File: rtl/pwc_frontend.sv
`timescale 1ns/1ps
module pwc_frontend
  import pwc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pulseIn,
  output pulseEvt_t evt
);
  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

  logic                 edgeToggle;
  logic [SYNC_STAGES:0] toggleSync;
  logic [SYNC_STAGES-1:0] levelSync;
  logic                 levelPrev;
  logic [LEN_W-1:0]     runLen;
  logic                 level;
  logic                 edgeSeen;
  logic                 fall;

  // flips on every rising input edge, however short the pulse
  always_ff @(posedge pulseIn or negedge rstN) begin
    if (!rstN) edgeToggle <= 1'b0;
    else       edgeToggle <= ~edgeToggle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toggleSync <= '0;
      levelSync  <= '0;
      levelPrev  <= 1'b0;
      runLen     <= '0;
    end else begin
      toggleSync <= {toggleSync[SYNC_STAGES-1:0], edgeToggle};
      levelSync  <= {levelSync[SYNC_STAGES-2:0], pulseIn};
      levelPrev  <= level;
      if (!level)               runLen <= '0;
      else if (runLen != LEN_MAX) runLen <= runLen + 1'b1;
    end
  end

  assign level    = levelSync[SYNC_STAGES-1];
  assign edgeSeen = toggleSync[SYNC_STAGES-1] ^ toggleSync[SYNC_STAGES];
  assign fall     = levelPrev && !level;

  always_comb begin
    evt.shortPulse = edgeSeen && !level;
    evt.levelHigh  = level;
    evt.reach1     = level && (runLen == LEN_W'(0));
    evt.reach2     = level && (runLen == LEN_W'(1));
    evt.reach3     = level && (runLen == LEN_W'(2));
    evt.fallEq1    = fall && (runLen == LEN_W'(1));
    evt.fallEq2    = fall && (runLen == LEN_W'(2));
  end
endmodule

// File: rtl/pwc_ctrl.sv
`timescale 1ns/1ps
module pwc_ctrl
  import pwc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [3:0]  wrMode,
  input  logic        gateTick,
  input  pulseEvt_t   evt,
  output logic [3:0]  mode,
  output accStrobe_t  stb
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        mode <= MODE_OFF;
    else if (regWrEn) mode <= wrMode;
  end

  always_comb begin
    stb.publish = gateTick;
    unique case (mode)
      MODE_SHORT: stb.bump = evt.shortPulse;
      MODE_GE1:   stb.bump = evt.reach1;
      MODE_EQ1:   stb.bump = evt.fallEq1;
      MODE_GE2:   stb.bump = evt.reach2;
      MODE_EQ2:   stb.bump = evt.fallEq2;
      MODE_GE3:   stb.bump = evt.reach3;
      MODE_HIGH:  stb.bump = evt.levelHigh;
      default:    stb.bump = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwc_accum.sv
`timescale 1ns/1ps
module pwc_accum
  import pwc_pkg::*;
#(
  parameter int CNT_W = 26
) (
  input  logic             clk,
  input  logic             rstN,
  input  accStrobe_t       stb,
  output logic [CNT_W-1:0] runCnt,
  output logic [CNT_W-1:0] pubCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
      pubCnt <= '0;
    end else if (stb.publish) begin
      pubCnt <= runCnt;
      runCnt <= stb.bump ? CNT_W'(1) : '0;
    end else if (stb.bump && runCnt != CNT_MAX) begin
      runCnt <= runCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwc_rate_counter.sv
`timescale 1ns/1ps
module pwc_rate_counter
  import pwc_pkg::*;
#(
  parameter int CNT_W       = 26,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        pulseIn,
  input  logic        gateTick
);
  localparam int FIELD_W = 26;

  pulseEvt_t        evt;
  accStrobe_t       stb;
  logic [3:0]       mode;
  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] pubCnt;

  pwc_frontend #(.SYNC_STAGES(SYNC_STAGES), .LEN_W(2)) uFront (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .evt(evt)
  );

  pwc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .wrMode(regWrData[31:28]),
    .gateTick(gateTick), .evt(evt), .mode(mode), .stb(stb)
  );

  pwc_accum #(.CNT_W(CNT_W)) uAccum (
    .clk(clk), .rstN(rstN), .stb(stb), .runCnt(runCnt), .pubCnt(pubCnt)
  );

  assign regRdData = {mode, 2'b00, FIELD_W'(pubCnt)};
endmodule

// File: rtl/pwc_rate_counter_chk.sv
`timescale 1ns/1ps
module pwc_rate_counter_chk #(
  parameter int CNT_W = 26
) (
  input logic             clk,
  input logic             rstN,
  input logic             gateTick,
  input logic [31:0]      regRdData,
  input logic [CNT_W-1:0] runCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [3:0] curMode;
  logic       modeIdle;
  assign curMode  = regRdData[31:28];
  assign modeIdle = !(curMode inside {4'h5, 4'h6, 4'h7, 4'hA, 4'hB, 4'hE, 4'hF});

  a_r3_off_no_count: assert property (@(posedge clk) disable iff (!rstN)
    (modeIdle && !gateTick) |=> $stable(runCnt));

  a_r9_field_holds: assert property (@(posedge clk) disable iff (!rstN)
    !gateTick |=> $stable(regRdData[25:0]));

  a_r9_restart: assert property (@(posedge clk) disable iff (!rstN)
    gateTick |=> (runCnt <= CNT_W'(1)));

  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (runCnt == CNT_MAX && !gateTick) |=> (runCnt == CNT_MAX));
endmodule

bind pwc_rate_counter pwc_rate_counter_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .gateTick(gateTick),
  .regRdData(regRdData), .runCnt(runCnt)
);

// File: tb/tb_pwc_rate_counter.sv
`timescale 1ns/1ps
module tb_pwc_rate_counter;
  localparam int CNT_W = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        pulseIn = 1'b0;
  logic        gateTick = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwc_rate_counter #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .pulseIn(pulseIn), .gateTick(gateTick)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); gateTick = 1'b1;
    @(negedge clk); gateTick = 1'b0;
  endtask

  task automatic shortPulse();
    @(negedge clk); pulseIn = 1'b1; #1; pulseIn = 1'b0;
    idle(4);
  endtask

  task automatic widePulse(input int k);
    @(negedge clk); #1; pulseIn = 1'b1; #(4 * k); pulseIn = 1'b0;
    idle(4);
  endtask

  // 2 short, 3 x one period, 2 x two periods, 1 x three, 1 x five
  task automatic sendMix();
    shortPulse(); shortPulse();
    widePulse(1); widePulse(1); widePulse(1);
    widePulse(2); widePulse(2);
    widePulse(3); widePulse(5);
  endtask

  task automatic runMode(input logic [3:0] m, input int exp, input string tag);
    writeReg({m, 28'h0});
    idle(6);
    tick();
    sendMix();
    idle(6);
    tick();
    check(regRdData, {m, 28'(exp)}, tag);
  endtask

  task automatic testReset();
    check(regRdData, 32'h0, "R1 reset value");
  endtask

  task automatic testRegister();
    writeReg(32'hA3FF_FFFF);
    check(regRdData, 32'hA000_0000, "R2 mode readback, gap and count field ignore writes");
    writeReg(32'h3000_0000);
    check(regRdData, 32'h3000_0000, "R2 unused code reads back");
  endtask

  task automatic testModes();
    runMode(4'h0, 0,  "R3 mode off");
    runMode(4'h3, 0,  "R3 unused code 3");
    runMode(4'h9, 0,  "R3 unused code 9");
    runMode(4'h5, 2,  "R4 short pulses");
    runMode(4'h6, 7,  "R5 at least one period");
    runMode(4'h7, 3,  "R5 exactly one period");
    runMode(4'hA, 4,  "R6 at least two periods");
    runMode(4'hB, 2,  "R6 exactly two periods");
    runMode(4'hE, 2,  "R7 at least three periods");
    runMode(4'hF, 15, "R8 high level periods");
  endtask

  task automatic testGate();
    logic [31:0] held;
    writeReg(32'h6000_0000);
    tick();
    widePulse(2); widePulse(4);
    idle(6);
    tick();
    check(regRdData, 32'h6000_0002, "R9 published window");
    held = regRdData;
    widePulse(1); widePulse(1); widePulse(1);
    idle(6);
    check(regRdData, held, "R9 field holds between strobes");
    tick();
    check(regRdData, 32'h6000_0003, "R9 new window after strobe");
    tick();
    check(regRdData, 32'h6000_0000, "R9 restart from zero");
  endtask

  task automatic testSaturate();
    writeReg(32'hF000_0000);
    tick();
    widePulse(300);
    idle(6);
    tick();
    check(regRdData, 32'hF000_00FF, "R10 saturation");
    tick();
    check(regRdData, 32'hF000_0000, "R10 restart after saturation");
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    testReset();
    testRegister();
    testModes();
    testGate();
    testSaturate();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule